// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Flags

This block watches the accesses that the left and right ports of a shared 1K x 8 memory make, and from them drives one active-low interrupt flag toward each port. The two highest words of the address space serve as mailboxes. A write by one port to the other port's mailbox raises that other port's flag. A read of its own mailbox by the owning port lowers its flag again. The message byte itself stays in the ordinary memory array. The block only sees the access events and never the data.

A mode input turns the doorbell function on or off. While it is off the two top words are plain memory and both flags stay inactive. The flags are registered. An access presented in one cycle therefore shows on the flag after the next rising clock edge. A port that the contention arbiter holds off keeps its chip select high, so it produces no event.

Top module: `mbox_irq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, both l_irq_n and r_irq_n are 1 (inactive).
- R2: A right-port write (r_sel_n=0, r_wr_n=0) to address 0x3FE while mbox_en=1 drives l_irq_n to 0 after the next rising edge.
- R3: A left-port read (l_sel_n=0, l_wr_n=1) of address 0x3FE while mbox_en=1 returns l_irq_n to 1 after the next rising edge, unless a set event for it falls in the same cycle.
- R4: A left-port write to address 0x3FF while mbox_en=1 drives r_irq_n to 0 after the next rising edge.
- R5: A right-port read of address 0x3FF while mbox_en=1 returns r_irq_n to 1 after the next rising edge, unless a set event for it falls in the same cycle.
- R6: An access with the port's chip select high (sel_n=1) generates no set or clear event, whatever the values on its wr_n and address pins.
- R7: When a set event and a clear event for the same flag fall in the same cycle, the flag becomes 0 (the set wins).
- R8: While mbox_en=0, both flags are 1 after every rising edge, whatever the accesses. Turning mbox_en back to 1 leaves them at 1 until a new set event occurs.
- R9: These accesses leave both flags unchanged: a write by a port to its own mailbox (left to 0x3FE, right to 0x3FF), a read of the other port's mailbox, and any access to another address.
- R10: With no set or clear event and mbox_en=1, each flag keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | 1 enables the mailbox doorbells, 0 makes the top words plain memory |
| l_sel_n | input | 1 | Left-port chip select, active low |
| l_wr_n | input | 1 | Left-port direction: 0 write, 1 read |
| l_addr | input | ADDR_W (10) | Left-port word address |
| r_sel_n | input | 1 | Right-port chip select, active low |
| r_wr_n | input | 1 | Right-port direction: 0 write, 1 read |
| r_addr | input | ADDR_W (10) | Right-port word address |
| l_irq_n | output | 1 | Interrupt flag toward the left port, active low |
| r_irq_n | output | 1 | Interrupt flag toward the right port, active low |

## Verification
A flag's set event, which comes from the peer port writing, and its clear event, which comes from the owner reading, can arrive in the same cycle, because the two ports are fully independent. The stimulus table provokes this for each flag. In one row the left port writes 0x3FF while the right port reads 0x3FF. In another row the right port writes 0x3FE while the left port reads 0x3FE. After the edge the bench expects the affected flag at 0, which shows that the set took priority and the message was not lost. Rows before these bring each flag to a known state, so a clear-wins design, or a design in which the two events cancel, gives a visibly different value.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   typedef enum logic {
      PORT_L = 1'b0,
      PORT_R = 1'b1
   } mbox_port_e;

   localparam int unsigned NUM_PORTS = 2;

   // Mailbox word owned by a port: left owns top-1, right owns top.
   function automatic int unsigned mbox_slot(input int unsigned addr_w,
                                             input int unsigned port_idx);
      return (32'd1 << addr_w) - 32'd2 + port_idx;
   endfunction

endpackage

// File: rtl/mbox_snoop.sv
module mbox_snoop #(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned RD_SLOT = 1022,
   parameter int unsigned WR_SLOT = 1023
) (
   input  logic              sel_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              wr_hit,
   output logic              rd_hit
);

   localparam logic [ADDR_W-1:0] RD_A = RD_SLOT[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] WR_A = WR_SLOT[ADDR_W-1:0];

   logic active;

   always_comb begin
      active = ~sel_n;
      wr_hit = active & ~wr_n & (addr == WR_A);
      rd_hit = active &  wr_n & (addr == RD_A);
   end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic set_ev,
   input  logic clr_ev,
   output logic flag_n
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_n <= 1'b1;
      else if (!en)      flag_n <= 1'b1;
      else if (set_ev)   flag_n <= 1'b0;
      else if (clr_ev)   flag_n <= 1'b1;
   end

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && set_ev && clr_ev) |=> !flag_n);

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !set_ev && !clr_ev) |=> $stable(flag_n));

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
   parameter int unsigned ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mbox_en,
   input  logic              l_sel_n,
   input  logic              l_wr_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_sel_n,
   input  logic              r_wr_n,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_irq_n,
   output logic              r_irq_n
);
   import mbox_pkg::*;

   localparam int unsigned NP = NUM_PORTS;
   localparam logic [ADDR_W-1:0] L_BOX = mbox_slot(ADDR_W, 0);
   localparam logic [ADDR_W-1:0] R_BOX = mbox_slot(ADDR_W, 1);

   generate
      if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_width
         $error("mbox_irq: ADDR_W must lie in 2..31");
      end
   endgenerate

   logic [NP-1:0]     sel_n_v;
   logic [NP-1:0]     wr_n_v;
   logic [ADDR_W-1:0] addr_v [NP];
   logic [NP-1:0]     wr_hit;
   logic [NP-1:0]     rd_hit;
   logic [NP-1:0]     irq_n_v;

   assign sel_n_v[PORT_L] = l_sel_n;
   assign sel_n_v[PORT_R] = r_sel_n;
   assign wr_n_v[PORT_L]  = l_wr_n;
   assign wr_n_v[PORT_R]  = r_wr_n;
   assign addr_v[0]       = l_addr;
   assign addr_v[1]       = r_addr;
   assign l_irq_n         = irq_n_v[PORT_L];
   assign r_irq_n         = irq_n_v[PORT_R];

   genvar p;
   generate
      for (p = 0; p < NP; p++) begin : g_port
         localparam int unsigned OWN  = mbox_slot(ADDR_W, p);
         localparam int unsigned PEER = mbox_slot(ADDR_W, NP - 1 - p);

         mbox_snoop #(
            .ADDR_W  (ADDR_W),
            .RD_SLOT (OWN),
            .WR_SLOT (PEER)
         ) u_snoop (
            .sel_n  (sel_n_v[p]),
            .wr_n   (wr_n_v[p]),
            .addr   (addr_v[p]),
            .wr_hit (wr_hit[p]),
            .rd_hit (rd_hit[p])
         );

         mbox_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (mbox_en),
            .set_ev (wr_hit[NP-1-p]),
            .clr_ev (rd_hit[p]),
            .flag_n (irq_n_v[p])
         );
      end
   endgenerate

   // R2
   l_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_en && !r_sel_n && !r_wr_n && r_addr == L_BOX) |=> !l_irq_n);

   // R4
   r_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_en && !l_sel_n && !l_wr_n && l_addr == R_BOX) |=> !r_irq_n);

   // R3
   l_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_en && !l_sel_n && l_wr_n && l_addr == L_BOX &&
       !(!r_sel_n && !r_wr_n && r_addr == L_BOX)) |=> l_irq_n);

   // R5
   r_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_en && !r_sel_n && r_wr_n && r_addr == R_BOX &&
       !(!l_sel_n && !l_wr_n && l_addr == R_BOX)) |=> r_irq_n);

   // R6
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbox_en && l_sel_n && r_sel_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

   // R8
   off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mbox_en |=> (l_irq_n && r_irq_n));

endmodule

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;

   localparam int unsigned AW = 10;
   localparam int NV = 15;

   // {en, l_sel_n, l_wr_n, l_addr, r_sel_n, r_wr_n, r_addr, exp_l, exp_r}
   localparam logic [26:0] VEC [NV] = '{
      {1'b1, 1'b1, 1'b1, 10'h3FE, 1'b1, 1'b0, 10'h3FF, 1'b1, 1'b1}, // R6 idle
      {1'b1, 1'b1, 1'b1, 10'h000, 1'b0, 1'b0, 10'h3FE, 1'b0, 1'b1}, // R2
      {1'b1, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1, 10'h000, 1'b0, 1'b1}, // R10
      {1'b1, 1'b0, 1'b0, 10'h3FE, 1'b0, 1'b1, 10'h3FE, 1'b0, 1'b1}, // R9
      {1'b1, 1'b0, 1'b1, 10'h3FE, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1}, // R3
      {1'b1, 1'b0, 1'b0, 10'h3FF, 1'b1, 1'b1, 10'h000, 1'b1, 1'b0}, // R4
      {1'b1, 1'b0, 1'b1, 10'h3FF, 1'b0, 1'b0, 10'h3FF, 1'b1, 1'b0}, // R9
      {1'b1, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1, 10'h3FF, 1'b1, 1'b0}, // R6
      {1'b1, 1'b1, 1'b1, 10'h000, 1'b0, 1'b1, 10'h3FF, 1'b1, 1'b1}, // R5
      {1'b1, 1'b0, 1'b0, 10'h3FF, 1'b0, 1'b1, 10'h3FF, 1'b1, 1'b0}, // R7
      {1'b1, 1'b0, 1'b1, 10'h3FE, 1'b0, 1'b0, 10'h3FE, 1'b0, 1'b0}, // R7
      {1'b1, 1'b0, 1'b1, 10'h1FE, 1'b0, 1'b0, 10'h2FF, 1'b0, 1'b0}, // R9
      {1'b0, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1}, // R8
      {1'b0, 1'b0, 1'b0, 10'h3FF, 1'b0, 1'b0, 10'h3FE, 1'b1, 1'b1}, // R8
      {1'b1, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1, 10'h000, 1'b1, 1'b1}  // R8
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mbox_en = 1'b1;
   logic          l_sel_n = 1'b1, l_wr_n = 1'b1, r_sel_n = 1'b1, r_wr_n = 1'b1;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic          l_irq_n, r_irq_n;

   int total = 0;
   int bad   = 0;

   always #2 clk = ~clk;

   mbox_irq #(.ADDR_W(AW)) u_mbox_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mbox_en (mbox_en),
      .l_sel_n (l_sel_n),
      .l_wr_n  (l_wr_n),
      .l_addr  (l_addr),
      .r_sel_n (r_sel_n),
      .r_wr_n  (r_wr_n),
      .r_addr  (r_addr),
      .l_irq_n (l_irq_n),
      .r_irq_n (r_irq_n)
   );

   task automatic check(input string tag, input logic act_l, input logic act_r,
                        input logic exp_l, input logic exp_r);
      total++;
      if (act_l !== exp_l || act_r !== exp_r) begin
         bad++;
         $display("FAIL %s: l_irq_n=%b r_irq_n=%b expected %b %b",
                  tag, act_l, act_r, exp_l, exp_r);
      end
   endtask

   task automatic idle_ports();
      l_sel_n = 1'b1; l_wr_n = 1'b1; l_addr = '0;
      r_sel_n = 1'b1; r_wr_n = 1'b1; r_addr = '0;
   endtask

   initial begin
      repeat (4000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: run did not end");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 during reset", l_irq_n, r_irq_n, 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", l_irq_n, r_irq_n, 1'b1, 1'b1);

      for (int i = 0; i < NV; i++) begin
         mbox_en = VEC[i][26];
         l_sel_n = VEC[i][25];
         l_wr_n  = VEC[i][24];
         l_addr  = VEC[i][23:14];
         r_sel_n = VEC[i][13];
         r_wr_n  = VEC[i][12];
         r_addr  = VEC[i][11:2];
         @(negedge clk);
         check($sformatf("vector %0d", i), l_irq_n, r_irq_n, VEC[i][1], VEC[i][0]);
      end

      // R2 R4: raise both, then idle for several cycles (R10)
      mbox_en = 1'b1;
      r_sel_n = 1'b0; r_wr_n = 1'b0; r_addr = 10'h3FE;
      l_sel_n = 1'b0; l_wr_n = 1'b0; l_addr = 10'h3FF;
      @(negedge clk);
      check("R2 R4 both set", l_irq_n, r_irq_n, 1'b0, 1'b0);
      idle_ports();
      repeat (3) @(negedge clk);
      check("R10 hold both", l_irq_n, r_irq_n, 1'b0, 1'b0);

      // R6: deselected left read of its mailbox clears nothing
      l_sel_n = 1'b1; l_wr_n = 1'b1; l_addr = 10'h3FE;
      @(negedge clk);
      check("R6 deselected read", l_irq_n, r_irq_n, 1'b0, 1'b0);
      idle_ports();

      // R8: disabling drops an asserted flag
      mbox_en = 1'b0;
      @(negedge clk);
      check("R8 disable clears", l_irq_n, r_irq_n, 1'b1, 1'b1);
      mbox_en = 1'b1;

      // R1: reset in the middle of operation
      r_sel_n = 1'b0; r_wr_n = 1'b0; r_addr = 10'h3FE;
      @(negedge clk);
      check("R2 set before reset", l_irq_n, r_irq_n, 1'b0, 1'b1);
      idle_ports();
      rst_n = 1'b0;
      #1;
      check("R1 async reset", l_irq_n, r_irq_n, 1'b1, 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after second reset", l_irq_n, r_irq_n, 1'b1, 1'b1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule